// File: doc/BRIEF.md
# Four-Port Serial Management Target

This block is the target side of a two-wire serial management bus: one clock line and one bidirectional data line. A single instance serves four transceiver register banks. All four banks share one bus and one set of three address strap inputs. The block samples the data line on every rising edge of the management clock and parses each frame in turn:

- a run of ones that forms the preamble;
- a start pattern;
- an opcode;
- a 5-bit device address and a 5-bit register address;
- a turnaround;
- a 16-bit data word.

The upper three device-address bits must equal the strap inputs. The lower two bits choose the port, so one instance answers at four consecutive bus addresses.

On a read, the block fetches the addressed word from the attached register bank as soon as the register address has arrived. It stays off the line for the first turnaround bit, drives a zero in the second turnaround bit, and then shifts the word out MSB first. On a write, the block collects the word and raises a one-cycle write strobe toward the bank on the clock pulse that follows the last data bit. The register bank sits outside the block and is reached through a port select, a register address, write data, a write strobe and combinational read data. The data pad is split into an input, an output and an output enable, and a pull-up outside the block resolves the line.

Top module: `mgmt_serial_target`

## Requirements
- R1: A frame is recognised only when at least 32 consecutive ones precede the start pattern. A frame preceded by fewer ones causes neither a write strobe nor any driving of the line.
- R2: The start pattern is a 0 followed by a 1. Any other pattern makes the block ignore the rest of the frame.
- R3: Opcode 10 selects a read and opcode 01 selects a write. Opcodes 00 and 11 abandon the frame, so no strobe is raised and the line is never driven.
- R4: The device address is sent MSB first. Its bits [4:2] must equal `phyStrap`, and on a mismatch the frame is ignored.
- R5: Device-address bits [1:0] appear on `regPort` as the selected port, and the register address appears on `regAddr`. Both are presented with the write strobe and used for the read fetch.
- R6: On a write, the turnaround bits must be 1 then 0. Any other turnaround pattern discards the write.
- R7: On a read, `mdioOe` stays low during the first turnaround bit period. In the second period the block drives 0, launched on the rising clock edge that samples the first turnaround bit.
- R8: On a read, the 16-bit word from `regRdata` follows MSB first, one bit launched per rising edge. `mdioOe` is high for exactly 17 bit periods and then drops.
- R9: On a valid write, `regWe` is high for exactly one clock period: the period that begins at the rising edge sampling the last data bit. The rising edge at its end is the 65th pulse of the frame. Before that period, `regWe` is low.
- R10: After a frame completes or is abandoned, a new run of at least 32 ones is required. A start pattern that follows only the idle bit is ignored.
- R11: While `rstN` is low, and after it is released, `mdioOe` and `regWe` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; every action happens on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| mdioIn | input | 1 | Resolved level of the data line |
| mdioOut | output | 1 | Level the block drives while enabled |
| mdioOe | output | 1 | Output enable for the data line |
| phyStrap | input | 3 | Upper three device-address bits this instance answers to |
| regPort | output | 2 | Port chosen by device-address bits [1:0] |
| regAddr | output | 5 | Captured register address |
| regWdata | output | 16 | Write word toward the register bank |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | 16 | Word read from the bank at `regPort`/`regAddr` |

## Verification
The hardest conditions to reach are the rejected frames that still look like frames. Examples are a preamble exactly one bit short, or a start pattern sent right after a completed read, with only the idle bit in front of it. Because idle ones count toward the preamble, the stimulus sends a single 0 before each run of ones, so the run length is exact. Every rejected write is then followed by a valid read of the same register, which shows at the ports that the bank word did not change. Reads check the line level and the enable in each of the 17 driven periods, and the periods on either side of them.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_HDR,
    ST_TA1,
    ST_TA2,
    ST_DATA,
    ST_COMMIT
  } mstState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // sample mdioIn into the receive shifter
    logic capHdr;    // latch port, register address and direction
    logic loadRd;    // fetch read word, start driving zero
    logic driveOut;  // launch next read bit
    logic relOe;     // release the line
    logic commit;    // write strobe toward the bank
  } mstStrobe_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mst_ctrl.sv
module mst_ctrl
  import mst_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int DATA_W   = 16,
  parameter int HDR_BITS = 13
) (
  input  logic       mdc,
  input  logic       rstN,
  input  logic       mdioIn,
  input  logic       hdrOk,
  input  logic       isRead,
  output mstStrobe_t strobe
);

  localparam int CNT_W  = $clog2((DATA_W > HDR_BITS) ? DATA_W : HDR_BITS);
  localparam int ONES_W = $clog2(PRE_LEN + 1);

  mstState_e          state, nextState;
  logic [CNT_W-1:0]   bitCnt;
  logic [ONES_W-1:0]  onesCnt;
  logic               hdrLast, dataLast, preambleDone;

  assign hdrLast      = (bitCnt == CNT_W'(HDR_BITS - 1));
  assign dataLast     = (bitCnt == CNT_W'(DATA_W - 1));
  assign preambleDone = (onesCnt >= ONES_W'(PRE_LEN));

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_PRE: begin
        if (!mdioIn && preambleDone) nextState = ST_HDR;
      end
      ST_HDR: begin
        strobe.shiftIn = 1'b1;
        if (hdrLast) begin
          if (hdrOk) begin
            strobe.capHdr = 1'b1;
            nextState     = ST_TA1;
          end else begin
            nextState = ST_PRE;
          end
        end
      end
      ST_TA1: begin
        if (isRead) begin
          strobe.loadRd = 1'b1;
          nextState     = ST_TA2;
        end else begin
          nextState = mdioIn ? ST_TA2 : ST_PRE;
        end
      end
      ST_TA2: begin
        if (isRead) begin
          strobe.driveOut = 1'b1;
          nextState       = ST_DATA;
        end else begin
          nextState = mdioIn ? ST_PRE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (isRead) begin
          if (dataLast) begin
            strobe.relOe = 1'b1;
            nextState    = ST_PRE;
          end else begin
            strobe.driveOut = 1'b1;
          end
        end else begin
          strobe.shiftIn = 1'b1;
          if (dataLast) nextState = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        strobe.commit = 1'b1;
        nextState     = ST_PRE;
      end
      default: nextState = ST_PRE;
    endcase
  end

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PRE;
      bitCnt  <= '0;
      onesCnt <= '0;
    end else begin
      state  <= nextState;
      bitCnt <= (nextState != state) ? '0 : bitCnt + 1'b1;
      if (state == ST_PRE && mdioIn) begin
        if (!preambleDone) onesCnt <= onesCnt + 1'b1;
      end else begin
        onesCnt <= '0;
      end
    end
  end

  // R1: header parsing begins only after a full preamble
  a_r1_full_preamble: assert property (@(posedge mdc) disable iff (!rstN)
    (state == ST_HDR && $past(state) == ST_PRE) |-> $past(onesCnt) >= ONES_W'(PRE_LEN));

  // R6: write data phase only after a 1-0 turnaround
  a_r6_write_turnaround: assert property (@(posedge mdc) disable iff (!rstN)
    (state == ST_DATA && $past(state) == ST_TA2 && !isRead) |-> !$past(mdioIn));

  // R9: strobe lasts one cycle and follows a write data phase
  a_r9_commit_single: assert property (@(posedge mdc) disable iff (!rstN)
    strobe.commit |=> !strobe.commit);
  a_r9_commit_after_data: assert property (@(posedge mdc) disable iff (!rstN)
    strobe.commit |-> ($past(state) == ST_DATA && !isRead));

endmodule

// File: rtl/mst_dpath.sv
module mst_dpath
  import mst_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int PORT_W   = 2,
  parameter int HDR_BITS = 13
) (
  input  logic                     mdc,
  input  logic                     rstN,
  input  logic                     mdioIn,
  input  logic [ADDR_W-PORT_W-1:0] phyStrap,
  input  mstStrobe_t               strobe,
  input  logic [DATA_W-1:0]        regRdata,
  output logic                     hdrOk,
  output logic                     isRead,
  output logic [PORT_W-1:0]        regPort,
  output logic [ADDR_W-1:0]        regAddr,
  output logic [DATA_W-1:0]        regWdata,
  output logic                     mdioOut,
  output logic                     mdioOe
);

  localparam int OE_SPAN = DATA_W + 1;
  localparam int OE_W    = $clog2(OE_SPAN + 1);

  logic [DATA_W-1:0]   shiftReg, rdShift;
  logic [HDR_BITS-1:0] hdrVec;
  logic                stBit;
  logic [1:0]          opField;
  logic [ADDR_W-1:0]   phyField, regField;

  // header layout, oldest bit highest: start tail, opcode, device, register
  assign hdrVec   = {shiftReg[HDR_BITS-2:0], mdioIn};
  assign stBit    = hdrVec[HDR_BITS-1];
  assign opField  = hdrVec[HDR_BITS-2 -: 2];
  assign phyField = hdrVec[2*ADDR_W-1 -: ADDR_W];
  assign regField = hdrVec[ADDR_W-1:0];

  assign hdrOk = stBit
              && (opField == OP_READ || opField == OP_WRITE)
              && (phyField[ADDR_W-1:PORT_W] == phyStrap);

  assign regWdata = shiftReg;

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rdShift  <= '0;
      regPort  <= '0;
      regAddr  <= '0;
      isRead   <= 1'b0;
      mdioOut  <= 1'b1;
      mdioOe   <= 1'b0;
    end else begin
      if (strobe.shiftIn) shiftReg <= {shiftReg[DATA_W-2:0], mdioIn};
      if (strobe.capHdr) begin
        regPort <= phyField[PORT_W-1:0];
        regAddr <= regField;
        isRead  <= (opField == OP_READ);
      end
      if (strobe.loadRd) begin
        rdShift <= regRdata;
        mdioOe  <= 1'b1;
        mdioOut <= 1'b0;
      end
      if (strobe.driveOut) begin
        mdioOut <= rdShift[DATA_W-1];
        rdShift <= {rdShift[DATA_W-2:0], 1'b0};
      end
      if (strobe.relOe) begin
        mdioOe  <= 1'b0;
        mdioOut <= 1'b1;
      end
    end
  end

  // checker-only count of consecutive driven cycles
  logic [OE_W-1:0] oeCnt;
  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN)       oeCnt <= '0;
    else if (mdioOe) oeCnt <= oeCnt + 1'b1;
    else             oeCnt <= '0;
  end

  // R3: the line is only ever driven for a read
  a_r3_drive_on_read: assert property (@(posedge mdc) disable iff (!rstN)
    mdioOe |-> isRead);

  // R7: the first driven period carries a zero
  a_r7_ta_zero: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

  // R8: driven window never exceeds, and always equals, 17 periods
  a_r8_oe_bound: assert property (@(posedge mdc) disable iff (!rstN)
    mdioOe |-> oeCnt < OE_W'(OE_SPAN));
  a_r8_oe_span: assert property (@(posedge mdc) disable iff (!rstN)
    $fell(mdioOe) |-> oeCnt == OE_W'(OE_SPAN));

endmodule

// File: rtl/mgmt_serial_target.sv
module mgmt_serial_target
  import mst_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic [2:0]        phyStrap,
  output logic [1:0]        regPort,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata
);

  localparam int PORT_W   = ADDR_W - 3;
  localparam int HDR_BITS = 2 * ADDR_W + 3;

  mstStrobe_t strobe;
  logic       hdrOk, isRead;

  mst_ctrl #(
    .PRE_LEN (PRE_LEN),
    .DATA_W  (DATA_W),
    .HDR_BITS(HDR_BITS)
  ) uCtrl (
    .mdc   (mdc),
    .rstN  (rstN),
    .mdioIn(mdioIn),
    .hdrOk (hdrOk),
    .isRead(isRead),
    .strobe(strobe)
  );

  mst_dpath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .PORT_W  (PORT_W),
    .HDR_BITS(HDR_BITS)
  ) uDpath (
    .mdc     (mdc),
    .rstN    (rstN),
    .mdioIn  (mdioIn),
    .phyStrap(phyStrap),
    .strobe  (strobe),
    .regRdata(regRdata),
    .hdrOk   (hdrOk),
    .isRead  (isRead),
    .regPort (regPort),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe)
  );

  assign regWe = strobe.commit;

  // R9: write strobe never overlaps a driven line
  a_r9_no_drive_on_commit: assert property (@(posedge mdc) disable iff (!rstN)
    regWe |-> !mdioOe);

endmodule

// File: tb/sim_mgmt_serial_target.sv
`timescale 1ns/1ps
module sim_mgmt_serial_target;

  localparam logic [2:0] STRAP = 3'b101;

  logic        mdc = 1'b0;
  logic        rstN = 1'b0;
  logic        mOe = 1'b0, mBit = 1'b1;
  logic        mdioOut, mdioOe, regWe;
  logic [1:0]  regPort;
  logic [4:0]  regAddr;
  logic [15:0] regWdata, regRdata;
  wire         busLine = mdioOe ? mdioOut : (mOe ? mBit : 1'b1);

  int compared = 0, mismatched = 0;
  int weCount = 0, oeCycles = 0;
  bit finished = 0;

  logic [15:0] bank    [4][32];
  logic [15:0] expBank [4][32];

  always #2 mdc = ~mdc;

  mgmt_serial_target u0 (
    .mdc(mdc), .rstN(rstN), .mdioIn(busLine), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .phyStrap(STRAP), .regPort(regPort), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata)
  );

  assign regRdata = bank[regPort][regAddr];
  always @(posedge mdc) if (regWe) bank[regPort][regAddr] <= regWdata;
  always @(negedge mdc) begin
    if (regWe)  weCount++;
    if (mdioOe) oeCycles++;
  end

  typedef struct packed {
    logic        rd;
    logic [5:0]  pre;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] dat;
    logic        ok;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd32, 5'b10100, 5'd3,  16'hA5C3, 1'b1},
    '{1'b0, 6'd40, 5'b10111, 5'd31, 16'h0001, 1'b1},
    '{1'b1, 6'd32, 5'b10100, 5'd3,  16'h0000, 1'b1},
    '{1'b1, 6'd32, 5'b10111, 5'd31, 16'h0000, 1'b1},
    '{1'b0, 6'd31, 5'b10101, 5'd7,  16'h1234, 1'b0},
    '{1'b1, 6'd32, 5'b10101, 5'd7,  16'h0000, 1'b1},
    '{1'b0, 6'd32, 5'b00101, 5'd7,  16'hFFFF, 1'b0},
    '{1'b1, 6'd32, 5'b10101, 5'd7,  16'h0000, 1'b1},
    '{1'b1, 6'd32, 5'b01110, 5'd3,  16'h0000, 1'b0},
    '{1'b0, 6'd32, 5'b10110, 5'd0,  16'h8000, 1'b1},
    '{1'b1, 6'd32, 5'b10110, 5'd0,  16'h0000, 1'b1}
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge mdc);
    mOe = 1'b1;
    mBit = b;
  endtask

  task automatic idleBit();
    @(negedge mdc);
    mOe = 1'b0;
  endtask

  // a leading 0 clears any idle ones so the preamble length is exact
  task automatic sendHdr(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] ra);
    sendBit(1'b0);
    repeat (pre) sendBit(1'b1);
    sendBit(st[1]); sendBit(st[0]);
    sendBit(op[1]); sendBit(op[0]);
    for (int i = 4; i >= 0; i--) sendBit(phy[i]);
    for (int i = 4; i >= 0; i--) sendBit(ra[i]);
  endtask

  task automatic doWrite(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] ra, input logic [1:0] ta,
                         input logic [15:0] dat, input logic ok, input string tag);
    int we0 = weCount;
    sendHdr(pre, st, op, phy, ra);
    sendBit(ta[1]); sendBit(ta[0]);
    for (int i = 15; i >= 0; i--) sendBit(dat[i]);
    check({15'd0, regWe}, 16'd0, {tag, " R9 no strobe before last data bit"});
    idleBit();
    if (ok) begin
      check({15'd0, regWe}, 16'd1, {tag, " R9 strobe on 65th pulse"});
      check({14'd0, regPort}, {14'd0, phy[1:0]}, {tag, " R5 port select"});
      check({11'd0, regAddr}, {11'd0, ra}, {tag, " R5 register address"});
      check(regWdata, dat, {tag, " R9 write word"});
      expBank[phy[1:0]][ra] = dat;
    end
    idleBit();
    check(16'(weCount - we0), ok ? 16'd1 : 16'd0, {tag, " R9 strobe count"});
  endtask

  task automatic doRead(input int pre, input logic [1:0] st, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] ra, input logic ok,
                        input string tag);
    int oe0 = oeCycles;
    logic [15:0] got = '0;
    sendHdr(pre, st, op, phy, ra);
    idleBit();
    check({15'd0, mdioOe}, 16'd0, {tag, " R7 first turnaround released"});
    @(negedge mdc);
    if (ok) check({14'd0, mdioOe, busLine}, 16'b10, {tag, " R7 second turnaround drives 0"});
    for (int i = 0; i < 16; i++) begin
      @(negedge mdc);
      got = {got[14:0], busLine};
    end
    @(negedge mdc);
    check({15'd0, mdioOe}, 16'd0, {tag, " R8 released after data"});
    check(16'(oeCycles - oe0), ok ? 16'd17 : 16'd0, {tag, " R8 driven period count"});
    check(got, ok ? expBank[phy[1:0]][ra] : 16'hFFFF, {tag, " R8 read word"});
  endtask

  initial begin
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 32; r++) begin
        bank[p][r] = '0;
        expBank[p][r] = '0;
      end
    repeat (3) @(negedge mdc);
    check({14'd0, mdioOe, regWe}, 16'd0, "R11 outputs during reset");
    rstN = 1'b1;
    repeat (2) @(negedge mdc);
    check({14'd0, mdioOe, regWe}, 16'd0, "R11 outputs after reset");

    // vector walk: R1 short preamble, R4 strap mismatch, R5 ports, R8/R9 main path
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].rd)
        doRead(int'(VECS[v].pre), 2'b01, 2'b10, VECS[v].phy, VECS[v].ra, VECS[v].ok,
               $sformatf("vec%0d R1/R4", v));
      else
        doWrite(int'(VECS[v].pre), 2'b01, 2'b01, VECS[v].phy, VECS[v].ra, 2'b10,
                VECS[v].dat, VECS[v].ok, $sformatf("vec%0d R1/R4", v));
    end

    // R2 bad start pattern
    doWrite(32, 2'b00, 2'b01, 5'b10101, 5'd11, 2'b10, 16'h5A5A, 1'b0, "R2 bad start");
    doRead(32, 2'b01, 2'b10, 5'b10101, 5'd11, 1'b1, "R2 readback");
    // R3 illegal opcodes
    doWrite(32, 2'b01, 2'b11, 5'b10101, 5'd12, 2'b10, 16'h3C3C, 1'b0, "R3 opcode 11");
    doRead(32, 2'b01, 2'b00, 5'b10101, 5'd12, 1'b0, "R3 opcode 00");
    doRead(32, 2'b01, 2'b10, 5'b10101, 5'd12, 1'b1, "R3 readback");
    // R6 bad write turnaround
    doWrite(32, 2'b01, 2'b01, 5'b10101, 5'd13, 2'b00, 16'hBEEF, 1'b0, "R6 bad turnaround");
    doRead(32, 2'b01, 2'b10, 5'b10101, 5'd13, 1'b1, "R6 readback");
    // R5 same register on all four ports
    for (int p = 0; p < 4; p++)
      doWrite(32, 2'b01, 2'b01, {STRAP, 2'(p)}, 5'd20, 2'b10, 16'(16'h1100 * (p + 1)),
              1'b1, $sformatf("R5 port%0d write", p));
    for (int p = 0; p < 4; p++)
      doRead(32, 2'b01, 2'b10, {STRAP, 2'(p)}, 5'd20, 1'b1, $sformatf("R5 port%0d read", p));
    // R10 frame right after a completed frame, no fresh preamble
    doRead(0, 2'b01, 2'b10, 5'b10110, 5'd0, 1'b0, "R10 no preamble after read");
    doWrite(0, 2'b01, 2'b01, 5'b10110, 5'd0, 2'b10, 16'h7777, 1'b0, "R10 no preamble write");
    doRead(32, 2'b01, 2'b10, 5'b10110, 5'd0, 1'b1, "R10 readback");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mdc);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule